// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Shared Prescalers

This block produces several pulse-width-modulated outputs from a small pool of shared timebases. There are three timebases. Each one divides a chosen source tick by a 16-bit divider and then steps an 8-bit cycle counter, and that counter sets the output period. Each channel names one timebase. It compares that timebase's cycle count against its own 8-bit duty value to decide when the pulse is active. Each channel can also invert its output, freeze at its idle level through a gate bit, or drive its pin as open-drain, pulling low and releasing high.

The two source clocks arrive as single-cycle tick enables that are synchronous to `clk`: a fast tick and a low-power tick derived from a 32.768 kHz clock. Software programs the block through a byte-wide write-only port. Divider, cycle-timer and duty changes are held back until the running period ends, so a reconfiguration never produces a short or torn pulse.

Top module: `pwm_bank`

## Requirements
- R1: After reset every channel is gated, the counter enable is clear and every pin drives low (`pwm_out`=0, `pwm_oe`=1). A channel stays at its idle level until its gate bit is cleared, even with the counter enable set.
- R2: Timebase p is programmed through three registers: divider low byte at address 0x10+4p, divider high byte at 0x11+4p, cycle timer at 0x12+4p. With divider D and cycle timer T, the period is (D+1)·(T+1) source ticks, and the pulse is active for min(duty, T+1)·(D+1) source ticks of each period.
- R3: A duty value of 0 gives a constantly inactive output. A duty value above T gives a constantly active output. Channel c's duty register is at address 0x20+c.
- R4: Bit p of the source register (address 0x01) selects the fast tick for timebase p when it is 1 and the low-power tick when it is 0.
- R5: Channel c takes its timebase index from the 2-bit field at bit (c mod 4)·2 of the group register at address 0x05+c/4. An index of NUM_PRS or more holds that channel inactive.
- R6: When bit c of the gate register (address 0x02) is 1, channel c sits at its inactive level.
- R7: When bit c of the polarity register (address 0x03) is 1, channel c's level is inverted, so the pulse is active-low and the idle level is high.
- R8: When bit c of the open-drain register (address 0x04) is 1, `pwm_out[c]` is 0. `pwm_oe[c]` is then 0 (released) while the level is high and 1 (driving low) while the level is low.
- R9: While bit 0 of the control register (address 0x00) is clear, all cycle counters are held at zero and every channel is inactive.
- R10: While counting, new divider, cycle-timer and duty values take effect only when the running period of the channel's timebase ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_tick | input | 1 | Single-cycle enable from the fast source clock |
| slow_tick | input | 1 | Single-cycle enable from the 32.768 kHz source clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | NUM_CH | Pin output value per channel |
| pwm_oe | output | NUM_CH | Pin output enable per channel |

## Verification
The hardest behaviour to reach from the ports is the deferred update. It only shows when a cycle-timer write and a duty write land inside a period that is already running. The stimulus counts edges from the enable write and places both writes before the first period ends. It then checks that the total active time over a fixed window matches one old period followed by three new ones. A second difficulty is that the low-power tick runs out of phase with the enable write. Every measurement window is therefore a whole number of periods, or a common multiple of the periods when channels use different timebases, which makes the expected active count independent of phase.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 8;
    localparam int DIV_W      = 16;
    localparam int CT_W       = 8;
    localparam int SEL_W      = 2;
    localparam int GRP_FIELDS = 4;

    localparam int A_CTRL     = 'h00;
    localparam int A_SRC      = 'h01;
    localparam int A_GATE     = 'h02;
    localparam int A_POL      = 'h03;
    localparam int A_OD       = 'h04;
    localparam int A_GRP      = 'h05;
    localparam int A_PRS      = 'h10;
    localparam int PRS_STRIDE = 4;
    localparam int A_DUTY     = 'h20;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int NUM_PRS = 3,
    parameter int AW      = ADDR_W,
    parameter int DW      = DATA_W,
    parameter int DVW     = DIV_W,
    parameter int CTW     = CT_W,
    parameter int SW      = SEL_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [AW-1:0]                   wr_addr,
    input  logic [DW-1:0]                   wr_data,
    output logic                            cnt_en,
    output logic [NUM_PRS-1:0]              src_fast,
    output logic [NUM_CH-1:0]               gate,
    output logic [NUM_CH-1:0]               pol,
    output logic [NUM_CH-1:0]               od,
    output logic [NUM_CH-1:0][SW-1:0]       sel,
    output logic [NUM_PRS-1:0][DVW-1:0]     div_cfg,
    output logic [NUM_PRS-1:0][CTW-1:0]     ct_cfg,
    output logic [NUM_CH-1:0][CTW-1:0]      duty_cfg
);
    localparam int HI_W = DVW - DW;

    typedef struct packed {
        logic                        en;
        logic [NUM_PRS-1:0]          src;
        logic [NUM_CH-1:0]           gate;
        logic [NUM_CH-1:0]           pol;
        logic [NUM_CH-1:0]           od;
        logic [NUM_CH-1:0][SW-1:0]   sel;
        logic [NUM_PRS-1:0][DVW-1:0] dv;
        logic [NUM_PRS-1:0][CTW-1:0] ct;
        logic [NUM_CH-1:0][CTW-1:0]  duty;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == AW'(A_CTRL)) r_d.en   = wr_data[0];
            if (wr_addr == AW'(A_SRC))  r_d.src  = wr_data[NUM_PRS-1:0];
            if (wr_addr == AW'(A_GATE)) r_d.gate = wr_data[NUM_CH-1:0];
            if (wr_addr == AW'(A_POL))  r_d.pol  = wr_data[NUM_CH-1:0];
            if (wr_addr == AW'(A_OD))   r_d.od   = wr_data[NUM_CH-1:0];
            for (int c = 0; c < NUM_CH; c++) begin
                if (wr_addr == AW'(A_GRP + c / GRP_FIELDS))
                    r_d.sel[c] = wr_data[(c % GRP_FIELDS) * SW +: SW];
                if (wr_addr == AW'(A_DUTY + c))
                    r_d.duty[c] = wr_data[CTW-1:0];
            end
            for (int p = 0; p < NUM_PRS; p++) begin
                if (wr_addr == AW'(A_PRS + p * PRS_STRIDE))
                    r_d.dv[p][DW-1:0] = wr_data;
                if (wr_addr == AW'(A_PRS + p * PRS_STRIDE + 1))
                    r_d.dv[p][DVW-1:DW] = wr_data[HI_W-1:0];
                if (wr_addr == AW'(A_PRS + p * PRS_STRIDE + 2))
                    r_d.ct[p] = wr_data[CTW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.gate <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt_en   = r_q.en;
    assign src_fast = r_q.src;
    assign gate     = r_q.gate;
    assign pol      = r_q.pol;
    assign od       = r_q.od;
    assign sel      = r_q.sel;
    assign div_cfg  = r_q.dv;
    assign ct_cfg   = r_q.ct;
    assign duty_cfg = r_q.duty;
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_bank_pkg::*;
#(
    parameter int DVW = DIV_W,
    parameter int CTW = CT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           tick,
    input  logic [DVW-1:0] div_new,
    input  logic [CTW-1:0] ct_new,
    output logic [CTW-1:0] cyc,
    output logic           boundary,
    output logic [CTW-1:0] ct_live
);
    typedef struct packed {
        logic [DVW-1:0] dcnt;
        logic [DVW-1:0] dsh;
        logic [CTW-1:0] ccnt;
        logic [CTW-1:0] csh;
    } pre_t;

    pre_t s_d, s_q;
    logic step;

    always_comb begin
        s_d      = s_q;
        step     = tick && (s_q.dcnt == s_q.dsh);
        boundary = run && step && (s_q.ccnt == s_q.csh);
        if (!run) begin
            s_d.dcnt = '0;
            s_d.ccnt = '0;
            s_d.dsh  = div_new;
            s_d.csh  = ct_new;
        end else if (tick) begin
            if (step) begin
                s_d.dcnt = '0;
                if (s_q.ccnt == s_q.csh) begin
                    s_d.ccnt = '0;
                    s_d.dsh  = div_new;
                    s_d.csh  = ct_new;
                end else begin
                    s_d.ccnt = s_q.ccnt + 1'b1;
                end
            end else begin
                s_d.dcnt = s_q.dcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cyc     = s_q.ccnt;
    assign ct_live = s_q.csh;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_bank_pkg::*;
#(
    parameter int CTW = CT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           gate,
    input  logic           pol,
    input  logic           od,
    input  logic           valid,
    input  logic [CTW-1:0] cyc,
    input  logic           bnd,
    input  logic [CTW-1:0] duty_new,
    output logic           pin_out,
    output logic           pin_oe,
    output logic           active,
    output logic [CTW-1:0] duty_live
);
    logic [CTW-1:0] duty_d, duty_q;
    logic           level;

    always_comb begin
        duty_d = duty_q;
        if (!run || gate || bnd) duty_d = duty_new;
        active  = run && !gate && valid && (cyc < duty_q);
        level   = active ^ pol;
        pin_out = od ? 1'b0 : level;
        pin_oe  = od ? !level : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) duty_q <= '0;
        else        duty_q <= duty_d;
    end

    assign duty_live = duty_q;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int NUM_PRS = 3,
    parameter int AW      = ADDR_W,
    parameter int DW      = DATA_W,
    parameter int DVW     = DIV_W,
    parameter int CTW     = CT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_tick,
    input  logic              slow_tick,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [NUM_CH-1:0] pwm_oe
);
    localparam int SW = SEL_W;

    logic                         cnt_en;
    logic [NUM_PRS-1:0]           src_fast;
    logic [NUM_CH-1:0]            gate, pol, od;
    logic [NUM_CH-1:0][SW-1:0]    sel;
    logic [NUM_PRS-1:0][DVW-1:0]  div_cfg;
    logic [NUM_PRS-1:0][CTW-1:0]  ct_cfg;
    logic [NUM_CH-1:0][CTW-1:0]   duty_cfg;
    logic [NUM_PRS-1:0][CTW-1:0]  cyc;
    logic [NUM_PRS-1:0][CTW-1:0]  ct_live;
    logic [NUM_PRS-1:0]           bnd;
    logic [NUM_CH-1:0]            ch_active;
    logic [NUM_CH-1:0][CTW-1:0]   duty_live;

    pwm_regs #(
        .NUM_CH(NUM_CH), .NUM_PRS(NUM_PRS), .AW(AW), .DW(DW),
        .DVW(DVW), .CTW(CTW), .SW(SW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt_en(cnt_en), .src_fast(src_fast),
        .gate(gate), .pol(pol), .od(od), .sel(sel), .div_cfg(div_cfg),
        .ct_cfg(ct_cfg), .duty_cfg(duty_cfg)
    );

    for (genvar p = 0; p < NUM_PRS; p++) begin : g_prs
        logic tick_p;
        assign tick_p = src_fast[p] ? fast_tick : slow_tick;
        pwm_prescaler #(.DVW(DVW), .CTW(CTW)) u_prs (
            .clk(clk), .rst_n(rst_n), .run(cnt_en), .tick(tick_p),
            .div_new(div_cfg[p]), .ct_new(ct_cfg[p]), .cyc(cyc[p]),
            .boundary(bnd[p]), .ct_live(ct_live[p])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [CTW-1:0] cyc_s;
        logic           bnd_s;
        logic           vld_s;
        always_comb begin
            cyc_s = '0;
            bnd_s = 1'b0;
            vld_s = 1'b0;
            for (int p = 0; p < NUM_PRS; p++) begin
                if (sel[c] == SW'(p)) begin
                    cyc_s = cyc[p];
                    bnd_s = bnd[p];
                    vld_s = 1'b1;
                end
            end
        end
        pwm_channel #(.CTW(CTW)) u_ch (
            .clk(clk), .rst_n(rst_n), .run(cnt_en), .gate(gate[c]),
            .pol(pol[c]), .od(od[c]), .valid(vld_s), .cyc(cyc_s),
            .bnd(bnd_s), .duty_new(duty_cfg[c]), .pin_out(pwm_out[c]),
            .pin_oe(pwm_oe[c]), .active(ch_active[c]),
            .duty_live(duty_live[c])
        );
    end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
    parameter int NUM_CH  = 4,
    parameter int NUM_PRS = 3,
    parameter int CTW     = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cnt_en,
    input logic [NUM_CH-1:0]            gate,
    input logic [NUM_CH-1:0]            od,
    input logic [NUM_CH-1:0]            pwm_out,
    input logic [NUM_CH-1:0]            ch_active,
    input logic [NUM_CH-1:0][CTW-1:0]   duty_live,
    input logic [NUM_PRS-1:0][CTW-1:0]  cyc,
    input logic [NUM_PRS-1:0]           bnd,
    input logic [NUM_PRS-1:0][CTW-1:0]  ct_live
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
        // R8
        od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            od[c] |-> !pwm_out[c]);
        // R6
        gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gate[c] |-> !ch_active[c]);
        // R3
        zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (duty_live[c] == '0) |-> !ch_active[c]);
        // R9
        halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cnt_en |-> !ch_active[c]);
    end

    for (genvar p = 0; p < NUM_PRS; p++) begin : g_p
        // R9
        halt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cnt_en |=> (cyc[p] == '0));
        // R10
        shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_en && !bnd[p]) |=> $stable(ct_live[p]));
        // R2
        count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cyc[p] <= ct_live[p]);
    end
endmodule

bind pwm_bank pwm_bank_chk #(
    .NUM_CH(NUM_CH), .NUM_PRS(NUM_PRS), .CTW(CTW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate), .od(od),
    .pwm_out(pwm_out), .ch_active(ch_active), .duty_live(duty_live),
    .cyc(cyc), .bnd(bnd), .ct_live(ct_live)
);

// File: tb/pwm_bank_test.sv
module pwm_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           fast_tick = 1'b1;
    logic           slow_tick;
    logic           wr_en = 1'b0;
    logic [7:0]     wr_addr = '0;
    logic [7:0]     wr_data = '0;
    logic [NCH-1:0] pwm_out, pwm_oe;
    logic [1:0]     sdiv = '0;

    int n_high [NCH];
    int n_rel  [NCH];
    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    int div_t  [3] = '{1, 0, 2};
    int ct_t   [3] = '{3, 4, 1};
    int rate_t [3] = '{1, 4, 1};
    int dv     [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) sdiv <= sdiv + 2'd1;
    assign slow_tick = (sdiv == 2'd0);

    pwm_bank uut (
        .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    task automatic sample();
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            if (pwm_oe[c] && pwm_out[c]) n_high[c]++;
            if (!pwm_oe[c]) n_rel[c]++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) sample();
    endtask

    task automatic wr(input int a, input int d);
        wr_addr = 8'(a);
        wr_data = 8'(d);
        wr_en   = 1'b1;
        sample();
        wr_en   = 1'b0;
    endtask

    task automatic clr();
        for (int c = 0; c < NCH; c++) begin
            n_high[c] = 0;
            n_rel[c]  = 0;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_prs(input int p, input int d, input int t);
        wr('h10 + 4*p, d & 255);
        wr('h11 + 4*p, d >> 8);
        wr('h12 + 4*p, t);
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    initial begin
        clr();
        // R1: reset state
        idle(3);
        for (int c = 0; c < NCH; c++) begin
            chk("R1 reset out", int'(pwm_out[c]), 0);
            chk("R1 reset oe", int'(pwm_oe[c]), 1);
        end
        rst_n = 1'b1;
        idle(2);

        // R1: gated out of reset even when counting
        set_prs(0, 1, 3);
        for (int c = 0; c < NCH; c++) wr('h20 + c, 2);
        wr('h01, 7);
        clr();
        wr('h00, 1);
        idle(15);
        for (int c = 0; c < NCH; c++) chk("R1 gated after reset", n_high[c], 0);

        // R2 R3 R4 R5: sweep of duty over each timebase
        wr('h00, 0);
        wr('h02, 0);
        wr('h01, 5);
        for (int p = 0; p < 3; p++) set_prs(p, div_t[p], ct_t[p]);
        for (int s = 0; s < 3; s++) begin
            for (int d = 0; d <= ct_t[s] + 1; d++) begin
                int per;
                wr('h00, 0);
                wr('h05, s | (s << 2) | (s << 4) | (s << 6));
                for (int c = 0; c < NCH; c++) begin
                    dv[c] = (d + c) % (ct_t[s] + 2);
                    wr('h20 + c, dv[c]);
                end
                per = (div_t[s] + 1) * (ct_t[s] + 1) * rate_t[s];
                clr();
                wr('h00, 1);
                idle(2*per - 1);
                for (int c = 0; c < NCH; c++)
                    chk("R2 R3 R4 sweep active count", n_high[c],
                        2 * imin(dv[c], ct_t[s] + 1) * (div_t[s] + 1) * rate_t[s]);
            end
        end

        // R5: mixed selection including an out-of-range index
        wr('h00, 0);
        wr('h05, 3 | (0 << 2) | (1 << 4) | (2 << 6));
        for (int c = 0; c < NCH; c++) wr('h20 + c, 2);
        clr();
        wr('h00, 1);
        idle(119);
        chk("R5 invalid index inactive", n_high[0], 0);
        chk("R5 ch1 on timebase 0", n_high[1], 60);
        chk("R5 R4 ch2 on slow timebase 1", n_high[2], 48);
        chk("R5 R3 ch3 on timebase 2 full", n_high[3], 120);

        // R6 R7 R8: gate, polarity, open-drain
        wr('h00, 0);
        wr('h05, 0);
        for (int c = 0; c < NCH; c++) wr('h20 + c, 1);
        wr('h02, 'h8);
        wr('h03, 'hA);
        wr('h04, 'h4);
        clr();
        wr('h00, 1);
        idle(15);
        chk("R2 plain channel", n_high[0], 4);
        chk("R7 inverted channel", n_high[1], 12);
        chk("R8 open-drain never high", n_high[2], 0);
        chk("R8 open-drain released", n_rel[2], 4);
        chk("R6 R7 gated inverted idle high", n_high[3], 16);

        // R9: counter enable clear halts everything
        wr('h03, 0);
        wr('h04, 0);
        wr('h02, 0);
        wr('h00, 0);
        clr();
        idle(10);
        for (int c = 0; c < NCH; c++) begin
            chk("R9 halted no pulse", n_high[c], 0);
            chk("R9 halted driving", n_rel[c], 0);
        end

        // R10: mid-period reconfiguration waits for the boundary
        set_prs(0, 0, 7);
        wr('h20, 4);
        for (int c = 1; c < NCH; c++) wr('h20 + c, 0);
        clr();
        wr('h00, 1);
        idle(2);
        wr('h12, 3);
        wr('h20, 2);
        idle(15);
        chk("R10 deferred update", n_high[0], 10);
        chk("R10 zero duty neighbour", n_high[1], 0);

        // R2: divider high byte
        wr('h00, 0);
        set_prs(2, 'h100, 1);
        wr('h05, 2 | (2 << 2) | (2 << 4) | (2 << 6));
        for (int c = 0; c < NCH; c++) wr('h20 + c, 1);
        clr();
        wr('h00, 1);
        idle(513);
        for (int c = 0; c < NCH; c++) chk("R2 high byte divider", n_high[c], 257);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule